// File: doc/BRIEF.md
# Serial-loaded quad DAC register bank

This block is the digital front end of a four-channel, 8-bit digital-to-analog converter. A host shifts a 12-bit command in serially, most significant bit first, while the active-low select is held low. When the select returns high, the command is decoded. Its 2-bit address picks one of four input registers, which takes the 8-bit data field. Two active-low control bits in the same command can switch every channel off, switch only the addressed channel off, or power the addressed channel up again.

The input registers form the first rank of a double buffer. The second rank, the DAC registers that drive the converters, changes only while the level-sensitive, active-low load input is asserted. While load is asserted, all four input registers are copied at once, and a write made during that time passes straight through. An asynchronous active-low clear zeroes both ranks at once. The serial pins and the load pin are brought into the system clock domain through two-flop synchronizers, and their edges are detected there.

Top module: `quad_dac_ctrl`

## Requirements
- R1: After reset, all four DAC codes are 0x00 and all four shutdown flags are 0.
- R2: A command is 12 bits, shifted in MSB first on rising serial-clock edges while select is low. Bit 11 is the active-low all-off bit, bit 10 the active-low addressed-off bit, bits 9:8 the address and bits 7:0 the data.
- R3: A rising edge of select writes the data field into the input register of the addressed channel (address k selects channel k, whose code appears on dac_codes_o bits 8k+7:8k). While load is high, the DAC codes do not change.
- R4: Serial-clock edges while select is high do not shift. A select pulse with no clocks after them rewrites the previously shifted command.
- R5: When more than 12 bits are shifted in one frame, the last 12 bits form the command.
- R6: While ldn_i is low, all four input registers are copied to the DAC registers. While ldn_i is high, the DAC codes hold.
- R7: A write made while ldn_i is held low reaches dac_codes_o without a separate load pulse.
- R8: clrn_i low zeroes both register ranks without waiting for a clock edge. The ranks stay zero after clrn_i rises, and clear takes priority over load.
- R9: A command with bit 11 at 0 sets all four shutdown flags.
- R10: A command with bit 11 at 1 and bit 10 at 0 sets only the addressed channel's shutdown flag and leaves the other flags unchanged.
- R11: A command with bits 11 and 10 both at 1 clears the addressed channel's shutdown flag and leaves the other flags unchanged.
- R12: Clear does not change the shutdown flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the whole block |
| sclk_i | input | 1 | Serial clock; data is taken on its rising edge |
| csn_i | input | 1 | Active-low frame select; its rising edge commits a command |
| sdi_i | input | 1 | Serial data, MSB first |
| ldn_i | input | 1 | Active-low, level-sensitive load of all DAC registers |
| clrn_i | input | 1 | Active-low asynchronous clear of both register ranks |
| dac_codes_o | output | 32 | DAC codes, channel k at bits 8k+7:8k |
| shdn_o | output | 4 | Shutdown flag for each channel, 1 = channel off |

## Verification
The hardest case to reach from the ports is proving that the shift register ignores clocks while select is high. The shift register cannot be read directly. The stimulus therefore clocks a complete, different command with select high, then pulses select with no clocks at all. After a load, the outputs must show the earlier command rewritten, not the stray one. A second hard case is the 14-bit frame: its two extra leading bits are zeros, so a design that keeps the first twelve bits would both misroute the data and switch every channel off.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    // Shutdown action carried by a decoded command
    typedef enum logic [1:0] {
        SD_ONE_ON  = 2'd0,
        SD_ONE_OFF = 2'd1,
        SD_ALL_OFF = 2'd2
    } sd_op_e;

    localparam int unsigned DEF_DATA_W      = 8;
    localparam int unsigned DEF_ADDR_W      = 2;
    localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int unsigned    W       = 4,
    parameter int unsigned    STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_comb begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= stg_d;
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter
    import qdac_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              sdi_s,
    output logic              cmd_vld_o,
    output sd_op_e            cmd_op_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [DATA_W-1:0] cmd_data_o,
    output logic [DATA_W+ADDR_W+1:0] shift_o
);

    localparam int unsigned WORD_W = DATA_W + ADDR_W + 2;
    localparam int unsigned ALL_B  = WORD_W - 1;
    localparam int unsigned ONE_B  = WORD_W - 2;

    typedef struct packed {
        logic              sclk_prev;
        logic              csn_prev;
        logic [WORD_W-1:0] sr;
        logic              vld;
        sd_op_e            op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        // shift only on a serial clock rise inside a frame
        if (sclk_s && !st_q.sclk_prev && !csn_s) begin
            st_d.sr = {st_q.sr[WORD_W-2:0], sdi_s};
        end
        // frame end: decode the last WORD_W bits
        if (csn_s && !st_q.csn_prev) begin
            st_d.vld  = 1'b1;
            st_d.addr = st_q.sr[DATA_W +: ADDR_W];
            st_d.data = st_q.sr[DATA_W-1:0];
            if (!st_q.sr[ALL_B])      st_d.op = SD_ALL_OFF;
            else if (!st_q.sr[ONE_B]) st_d.op = SD_ONE_OFF;
            else                      st_d.op = SD_ONE_ON;
        end
        st_d.sclk_prev = sclk_s;
        st_d.csn_prev  = csn_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.csn_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_vld_o  = st_q.vld;
    assign cmd_op_o   = st_q.op;
    assign cmd_addr_o = st_q.addr;
    assign cmd_data_o = st_q.data;
    assign shift_o    = st_q.sr;

endmodule

// File: rtl/qdac_bank.sv
module qdac_bank
    import qdac_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr_n,
    input  logic                         ld_act,
    input  logic                         wr_vld,
    input  sd_op_e                       wr_op,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [(1<<ADDR_W)*DATA_W-1:0] codes_o,
    output logic [(1<<ADDR_W)-1:0]        shdn_o
);

    localparam int unsigned NCH = 1 << ADDR_W;

    typedef struct packed {
        logic [NCH-1:0][DATA_W-1:0] in_reg;
        logic [NCH-1:0][DATA_W-1:0] dac_reg;
    } rank_t;

    rank_t          rank_d, rank_q;
    logic [NCH-1:0] shdn_d, shdn_q;
    logic           arst_n;

    // clear joins reset for the two code ranks only
    assign arst_n = rst_n & clr_n;

    always_comb begin
        rank_d = rank_q;
        shdn_d = shdn_q;
        if (wr_vld) begin
            rank_d.in_reg[wr_addr] = wr_data;
            unique case (wr_op)
                SD_ALL_OFF: shdn_d          = '1;
                SD_ONE_OFF: shdn_d[wr_addr] = 1'b1;
                default:    shdn_d[wr_addr] = 1'b0;
            endcase
        end
        // load copies the updated first rank, so a same-cycle write passes through
        if (ld_act) rank_d.dac_reg = rank_d.in_reg;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) rank_q <= '0;
        else         rank_q <= rank_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shdn_q <= '0;
        else        shdn_q <= shdn_d;
    end

    assign codes_o = rank_q.dac_reg;
    assign shdn_o  = shdn_q;

endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl
    import qdac_pkg::*;
#(
    parameter int unsigned DATA_W      = DEF_DATA_W,
    parameter int unsigned ADDR_W      = DEF_ADDR_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sclk_i,
    input  logic                          csn_i,
    input  logic                          sdi_i,
    input  logic                          ldn_i,
    input  logic                          clrn_i,
    output logic [(1<<ADDR_W)*DATA_W-1:0] dac_codes_o,
    output logic [(1<<ADDR_W)-1:0]        shdn_o
);

    localparam int unsigned WORD_W = DATA_W + ADDR_W + 2;

    logic [3:0]        pins_s;
    logic              sclk_s, csn_s, sdi_s, ldn_s, ld_act;
    logic              cmd_vld;
    sd_op_e            cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic [WORD_W-1:0] shift_word;

    // order {load, select, serial clock, data}; idle levels 1,1,0,0
    qdac_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ldn_i, csn_i, sclk_i, sdi_i}),
        .q_o   (pins_s)
    );

    assign {ldn_s, csn_s, sclk_s, sdi_s} = pins_s;
    assign ld_act = ~ldn_s;

    qdac_shifter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sclk_s),
        .csn_s      (csn_s),
        .sdi_s      (sdi_s),
        .cmd_vld_o  (cmd_vld),
        .cmd_op_o   (cmd_op),
        .cmd_addr_o (cmd_addr),
        .cmd_data_o (cmd_data),
        .shift_o    (shift_word)
    );

    qdac_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_n   (clrn_i),
        .ld_act  (ld_act),
        .wr_vld  (cmd_vld),
        .wr_op   (cmd_op),
        .wr_addr (cmd_addr),
        .wr_data (cmd_data),
        .codes_o (dac_codes_o),
        .shdn_o  (shdn_o)
    );

endmodule

// File: rtl/qdac_checker.sv
module qdac_checker
    import qdac_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          clrn_i,
    input logic                          ld_act,
    input logic                          csn_s,
    input logic                          cmd_vld,
    input sd_op_e                        cmd_op,
    input logic [ADDR_W-1:0]             cmd_addr,
    input logic [DATA_W-1:0]             cmd_data,
    input logic [DATA_W+ADDR_W+1:0]      shift_word,
    input logic [(1<<ADDR_W)*DATA_W-1:0] dac_codes_o,
    input logic [(1<<ADDR_W)-1:0]        shdn_o
);

    assert_no_shift_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> $stable(shift_word));

    assert_hold_no_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_act && clrn_i) |=> ($stable(dac_codes_o) || dac_codes_o == '0));

    assert_pass_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && ld_act && clrn_i) |=>
        (!clrn_i || dac_codes_o[int'($past(cmd_addr))*DATA_W +: DATA_W] == $past(cmd_data)));

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clrn_i |-> dac_codes_o == '0);

    assert_all_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_op == SD_ALL_OFF) |=> &shdn_o);

    assert_one_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_op == SD_ONE_OFF) |=> shdn_o[$past(cmd_addr)]);

    assert_one_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_op == SD_ONE_ON) |=> !shdn_o[$past(cmd_addr)]);

    assert_clear_keeps_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_vld && !clrn_i) |=> $stable(shdn_o));

endmodule

bind quad_dac_ctrl qdac_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clrn_i      (clrn_i),
    .ld_act      (ld_act),
    .csn_s       (csn_s),
    .cmd_vld     (cmd_vld),
    .cmd_op      (cmd_op),
    .cmd_addr    (cmd_addr),
    .cmd_data    (cmd_data),
    .shift_word  (shift_word),
    .dac_codes_o (dac_codes_o),
    .shdn_o      (shdn_o)
);

// File: tb/test_quad_dac_ctrl.sv
module test_quad_dac_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_i = 1'b0, csn_i = 1'b1, sdi_i = 1'b0;
    logic        ldn_i = 1'b1, clrn_i = 1'b1;
    logic [31:0] dac_codes_o;
    logic [3:0]  shdn_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    quad_dac_ctrl i_quad_dac_ctrl (
        .clk (clk), .rst_n (rst_n), .sclk_i (sclk_i), .csn_i (csn_i),
        .sdi_i (sdi_i), .ldn_i (ldn_i), .clrn_i (clrn_i),
        .dac_codes_o (dac_codes_o), .shdn_o (shdn_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clock_bit(logic b);
        sdi_i = b;
        wait_clk(3);
        sclk_i = 1'b1;
        wait_clk(3);
        sclk_i = 1'b0;
    endtask

    // one frame of n bits, MSB of the n first
    task automatic send_bits(logic [15:0] w, int n);
        csn_i = 1'b0;
        wait_clk(3);
        for (int i = n - 1; i >= 0; i--) clock_bit(w[i]);
        wait_clk(3);
        csn_i = 1'b1;
        wait_clk(8);
    endtask

    function automatic logic [15:0] cmd(logic all_n, logic one_n, logic [1:0] a, logic [7:0] d);
        return {4'b0, all_n, one_n, a, d};
    endfunction

    task automatic load_pulse();
        ldn_i = 1'b0;
        wait_clk(6);
        ldn_i = 1'b1;
        wait_clk(6);
    endtask

    task automatic t_reset();
        check("R1 codes", dac_codes_o, 32'h0);
        check("R1 shdn", {28'h0, shdn_o}, 32'h0);
    endtask

    task automatic t_buffer();
        send_bits(cmd(1, 1, 2'd0, 8'h5A), 12);
        check("R3 no load yet", dac_codes_o, 32'h0);
        send_bits(cmd(1, 1, 2'd1, 8'h3C), 12);
        send_bits(cmd(1, 1, 2'd2, 8'hC3), 12);
        send_bits(cmd(1, 1, 2'd3, 8'h81), 12);
        check("R3 still held", dac_codes_o, 32'h0);
        load_pulse();
        check("R6 R2 all loaded", dac_codes_o, 32'h81C33C5A);
        check("R11 all on", {28'h0, shdn_o}, 32'h0);
    endtask

    task automatic t_cs_high();
        logic [15:0] w = cmd(1, 1, 2'd1, 8'hEE);
        for (int i = 11; i >= 0; i--) clock_bit(w[i]);
        wait_clk(3);
        csn_i = 1'b0;
        wait_clk(4);
        csn_i = 1'b1;
        wait_clk(8);
        load_pulse();
        check("R4 idle clocks ignored", dac_codes_o, 32'h81C33C5A);
    endtask

    task automatic t_long();
        send_bits({2'b00, 2'b11, 2'b01, 8'h77, 2'b00} >> 2, 14);
        load_pulse();
        check("R5 last 12 bits", dac_codes_o, 32'h81C3775A);
        check("R5 no spurious shutdown", {28'h0, shdn_o}, 32'h0);
    endtask

    task automatic t_pass();
        ldn_i = 1'b0;
        wait_clk(6);
        send_bits(cmd(1, 1, 2'd2, 8'h42), 12);
        check("R7 pass through", dac_codes_o, 32'h8142775A);
        ldn_i = 1'b1;
        wait_clk(6);
    endtask

    task automatic t_shutdown();
        send_bits(cmd(0, 1, 2'd1, 8'h10), 12);
        check("R9 all off", {28'h0, shdn_o}, 32'hF);
        send_bits(cmd(1, 1, 2'd2, 8'h20), 12);
        check("R11 ch2 on", {28'h0, shdn_o}, 32'hB);
        send_bits(cmd(1, 1, 2'd0, 8'h30), 12);
        check("R11 ch0 on", {28'h0, shdn_o}, 32'hA);
        send_bits(cmd(1, 0, 2'd2, 8'h40), 12);
        check("R10 ch2 off only", {28'h0, shdn_o}, 32'hE);
    endtask

    task automatic t_clear();
        load_pulse();
        check("R6 shutdown words still load", dac_codes_o, 32'h81401030);
        ldn_i = 1'b0;
        #3 clrn_i = 1'b0;
        #3;
        check("R8 async zero", dac_codes_o, 32'h0);
        wait_clk(4);
        check("R8 clear over load", dac_codes_o, 32'h0);
        check("R12 flags kept", {28'h0, shdn_o}, 32'hE);
        clrn_i = 1'b1;
        ldn_i  = 1'b1;
        wait_clk(6);
        load_pulse();
        check("R8 input rank zeroed", dac_codes_o, 32'h0);
    endtask

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_buffer();
        t_cs_high();
        t_long();
        t_pass();
        t_shutdown();
        t_clear();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

endmodule